// File: doc/BRIEF.md
# Bus Activity Monitor with Watermark Interrupts

This block watches the activity of several bus clients, one channel per client. On every clock where a channel's activity pulse is high, the channel adds its programmed weight to a running count. A shared timebase splits time into sampling periods of a whole number of milliseconds. At the close of each period the channel takes the count as that period's sample, starts a fresh count, and spends one evaluation cycle on the sample. In that cycle it updates an exponential moving average, compares the sample with an upper and a lower watermark, and compares the new average with a second pair of watermarks.

A sample that stays above the upper watermark, or below the lower one, for a programmed number of periods in a row sets a sticky status flag. So does an average that lands beyond its own watermarks. Each of the four conditions has its own enable. Software clears a flag by writing a one to it. A global status word shows one bit per channel, and a single interrupt output is high while any flag in any channel is set.

Each channel is driven by a three-state machine. IDLE is the stopped state. COUNT accumulates activity. JUDGE is the single evaluation cycle. The transitions are named as follows. START goes from IDLE to COUNT on the first cycle in which both the enable bit and the periodic bit are set. CLOSE goes from COUNT to JUDGE on the period-end strobe. RESUME goes from JUDGE back to COUNT on the next cycle. STOP goes from any state to IDLE whenever either bit is clear.

Top module: `act_monitor`

## Requirements
- R1: After reset, every register reads zero, no channel runs, and `irq` is low.
- R2: One millisecond is TICK_DIV clocks. The period register at 0x004 holds the period length in milliseconds minus one, 8 bits wide, so periods run from 1 to 256 ms. One period-end strobe is issued per period, and two strobes are never on adjacent cycles.
- R3: On each clock where a running channel (COUNT or JUDGE) sees its pulse high, the weight register (offset 0x18) is added to the count, and the sum saturates at 0xFFFFFFFF. The sample taken at period end includes the pulse of that final cycle.
- R4: In the cycle after a period end, the average becomes avg + ((sample - avg) >>> (K+1)). This is computed in signed arithmetic and truncated to 32 bits. K is control bits 12:10, and the average reads back at offset 0x20. A write to offset 0x0C stores the value and also replaces the average in the same edge, taking priority over an evaluation.
- R5: If control bit 30 is set and the sample is strictly greater than the upper watermark (offset 0x04) for N+1 periods in a row, status bit 31 is set. N is control bits 28:26. The run counter restarts from zero after it fires and after any period that is not above.
- R6: If control bit 29 is set and the sample is strictly less than the lower watermark (offset 0x08) for M+1 periods in a row, status bit 30 is set. M is control bits 25:23. The run counter restarts in the same way as in R5.
- R7: If the new average is strictly greater than offset 0x10 and control bit 21 is set, status bit 29 is set. If it is strictly less than offset 0x14 and control bit 20 is set, status bit 28 is set.
- R8: The status register at offset 0x24 is write-one-to-clear on bits 31:28. A flag set in the same cycle as its clear stays set.
- R9: Bit c of the global status register (address 0x000) is high when channel c has any status flag set. `irq` is the OR of these bits and rises only after an evaluation cycle.
- R10: A channel runs only when control bit 31 (enable) and bit 18 (periodic) are both set. Clearing either bit, for example by writing zero to control, discards the count, clears the run counters and stops evaluations. Status and the average are kept.
- R11: A condition whose enable bit is clear never sets its status flag, whatever the samples are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address (channel c at CH_BASE + 64*c) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| act_pulse | input | NCH | Activity pulse per channel |
| irq | output | 1 | Global interrupt, high while any flag is set |

## Verification
The bench builds the block with two channels and TICK_DIV = 4. With the period register set to 2, a sampling period is twelve clocks, so runs of consecutive periods, average decay across several halvings and hysteresis-counter restarts all fit into a few hundred cycles. Two channels with different weights, window lengths and condition enables exercise address decode, the per-channel global bits and the disabled-condition case side by side. An all-ones weight reaches count saturation within one period.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;

    localparam int DATA_W    = 32;
    localparam int OFS_W     = 6;
    localparam int CH_STRIDE = 64;
    localparam int RUN_W     = 3;
    localparam int K_W       = 3;
    localparam int ST_W      = 4;

    // status flag positions inside the 4-bit flag vector (maps to bits 31:28)
    localparam int ST_CONS_HI = 3;
    localparam int ST_CONS_LO = 2;
    localparam int ST_AVG_HI  = 1;
    localparam int ST_AVG_LO  = 0;

    localparam logic [OFS_W-1:0] OFS_CTRL   = 6'h00;
    localparam logic [OFS_W-1:0] OFS_HI     = 6'h04;
    localparam logic [OFS_W-1:0] OFS_LO     = 6'h08;
    localparam logic [OFS_W-1:0] OFS_INIT   = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_AVG_HI = 6'h10;
    localparam logic [OFS_W-1:0] OFS_AVG_LO = 6'h14;
    localparam logic [OFS_W-1:0] OFS_WEIGHT = 6'h18;
    localparam logic [OFS_W-1:0] OFS_AVG    = 6'h20;
    localparam logic [OFS_W-1:0] OFS_STS    = 6'h24;

    typedef struct packed {
        logic             en;          // 31
        logic             cons_hi_en;  // 30
        logic             cons_lo_en;  // 29
        logic [RUN_W-1:0] hi_num;      // 28:26
        logic [RUN_W-1:0] lo_num;      // 25:23
        logic             rsv22;
        logic             avg_hi_en;   // 21
        logic             avg_lo_en;   // 20
        logic             rsv19;
        logic             periodic;    // 18
        logic [4:0]       rsv17_13;
        logic [K_W-1:0]   k;           // 12:10
        logic [9:0]       rsv9_0;
    } ctrl_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_JUDGE = 2'd2
    } ch_state_e;

    function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        logic [DATA_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DATA_W] ? {DATA_W{1'b1}} : s[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/act_tick_gen.sv
module act_tick_gen #(
    parameter int TICK_DIV = 1000,
    parameter int PER_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_m1,
    output logic             period_end
);
    // TICK_DIV must be at least 2 so that period ends never fall on adjacent cycles
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] ms_q;
    logic             ms_tick;

    assign ms_tick    = (pre_q == PRE_LAST);
    assign period_end = ms_tick && (ms_q >= period_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else begin
            pre_q <= ms_tick ? '0 : pre_q + 1'b1;
            if (ms_tick) begin
                ms_q <= period_end ? '0 : ms_q + 1'b1;
            end
        end
    end

    AST_END_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !period_end); // R2

endmodule

// File: rtl/act_chan.sv
module act_chan
    import act_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end,
    input  logic              pulse,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              any_flag,
    output logic              in_judge
);
    ctrl_t             cfg_q;
    logic [DATA_W-1:0] hi_q, lo_q, init_q, ahi_q, alo_q, wt_q;
    logic [DATA_W-1:0] acc_q, snap_q, avg_q;
    logic [ST_W-1:0]   sts_q;
    logic [RUN_W-1:0]  run_hi_q, run_lo_q;
    ch_state_e         state_q, state_d;

    logic              run_ok, judge_go;
    logic [DATA_W-1:0] acc_add;

    assign run_ok   = cfg_q.en & cfg_q.periodic;
    assign judge_go = run_ok && (state_q == CH_JUDGE);
    assign acc_add  = sat_add(acc_q, pulse ? wt_q : '0);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!run_ok) begin
            state_d = CH_IDLE;                      // STOP
        end else begin
            unique case (state_q)
                CH_IDLE:  state_d = CH_COUNT;       // START
                CH_COUNT: if (period_end) state_d = CH_JUDGE; // CLOSE
                CH_JUDGE: state_d = CH_COUNT;       // RESUME
                default:  state_d = CH_IDLE;
            endcase
        end
    end

    // ---------------- evaluation datapath ----------------
    logic                     hit_hi, hit_lo, fire_hi, fire_lo;
    logic [RUN_W-1:0]         run_hi_d, run_lo_d;
    logic signed [DATA_W:0]   diff, step;
    logic [K_W:0]             shamt;
    logic [DATA_W-1:0]        avg_new;
    logic [ST_W-1:0]          setv, clrv;

    always_comb begin
        hit_hi   = cfg_q.cons_hi_en && (snap_q > hi_q);
        hit_lo   = cfg_q.cons_lo_en && (snap_q < lo_q);
        fire_hi  = hit_hi && (run_hi_q >= cfg_q.hi_num);
        fire_lo  = hit_lo && (run_lo_q >= cfg_q.lo_num);
        run_hi_d = (!hit_hi || fire_hi) ? '0 : run_hi_q + 1'b1;
        run_lo_d = (!hit_lo || fire_lo) ? '0 : run_lo_q + 1'b1;

        shamt    = {1'b0, cfg_q.k} + 1'b1;
        diff     = $signed({1'b0, snap_q}) - $signed({1'b0, avg_q});
        step     = diff >>> shamt;
        avg_new  = avg_q + step[DATA_W-1:0];

        setv = '0;
        if (judge_go) begin
            setv[ST_CONS_HI] = fire_hi;
            setv[ST_CONS_LO] = fire_lo;
            setv[ST_AVG_HI]  = cfg_q.avg_hi_en && (avg_new > ahi_q);
            setv[ST_AVG_LO]  = cfg_q.avg_lo_en && (avg_new < alo_q);
        end
        clrv = (wr_en && ofs == OFS_STS) ? wdata[DATA_W-1 -: ST_W] : '0;
    end

    // ---------------- state-dependent registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            snap_q   <= '0;
            avg_q    <= '0;
            sts_q    <= '0;
            run_hi_q <= '0;
            run_lo_q <= '0;
        end else begin
            if (!run_ok || state_q == CH_IDLE) begin
                acc_q <= '0;
            end else if (state_q == CH_COUNT && period_end) begin
                snap_q <= acc_add;
                acc_q  <= '0;
            end else begin
                acc_q <= acc_add;
            end

            if (!run_ok) begin
                run_hi_q <= '0;
                run_lo_q <= '0;
            end else if (judge_go) begin
                run_hi_q <= run_hi_d;
                run_lo_q <= run_lo_d;
            end

            if (wr_en && ofs == OFS_INIT) avg_q <= wdata;
            else if (judge_go)            avg_q <= avg_new;

            sts_q <= (sts_q & ~clrv) | setv;
        end
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            init_q <= '0;
            ahi_q  <= '0;
            alo_q  <= '0;
            wt_q   <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CTRL:   cfg_q  <= ctrl_t'(wdata);
                OFS_HI:     hi_q   <= wdata;
                OFS_LO:     lo_q   <= wdata;
                OFS_INIT:   init_q <= wdata;
                OFS_AVG_HI: ahi_q  <= wdata;
                OFS_AVG_LO: alo_q  <= wdata;
                OFS_WEIGHT: wt_q   <= wdata;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        any_flag = |sts_q;
        in_judge = judge_go;
        case (ofs)
            OFS_CTRL:   rdata = cfg_q;
            OFS_HI:     rdata = hi_q;
            OFS_LO:     rdata = lo_q;
            OFS_INIT:   rdata = init_q;
            OFS_AVG_HI: rdata = ahi_q;
            OFS_AVG_LO: rdata = alo_q;
            OFS_WEIGHT: rdata = wt_q;
            OFS_AVG:    rdata = avg_q;
            OFS_STS:    rdata = {sts_q, {(DATA_W-ST_W){1'b0}}};
            default:    rdata = '0;
        endcase
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (state_q == CH_IDLE)); // R10
    AST_END_TO_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && state_q == CH_COUNT && period_end) |=> (state_q == CH_JUDGE)); // R4
    AST_W1C_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_STS && wdata[DATA_W-1] && !judge_go) |=> !sts_q[ST_CONS_HI]); // R8
    AST_HI_FROM_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[ST_CONS_HI]) |-> $past(state_q == CH_JUDGE)); // R5
    AST_LO_FROM_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[ST_CONS_LO]) |-> $past(state_q == CH_JUDGE)); // R6

endmodule

// File: rtl/act_monitor.sv
module act_monitor
    import act_mon_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int AW       = 12,
    parameter int TICK_DIV = 1000,
    parameter int PER_W    = 8,
    parameter int CH_BASE  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    act_pulse,
    output logic              irq
);
    localparam int SLOT_W    = AW - OFS_W;
    localparam int BASE_SLOT = CH_BASE / CH_STRIDE;
    localparam logic [AW-1:0] GADDR_STS    = '0;
    localparam logic [AW-1:0] GADDR_PERIOD = AW'(4);

    logic [PER_W-1:0]  period_q;
    logic              period_end;
    logic [NCH-1:0]    ch_sel, ch_flag, ch_judge;
    logic [DATA_W-1:0] ch_rd [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   period_q <= '0;
        else if (bus_wr && bus_addr == GADDR_PERIOD)  period_q <= bus_wdata[PER_W-1:0];
    end

    act_tick_gen #(.TICK_DIV(TICK_DIV), .PER_W(PER_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_m1  (period_q),
        .period_end (period_end)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_sel[g] = (bus_addr[AW-1:OFS_W] == SLOT_W'(BASE_SLOT + g));

        act_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .period_end (period_end),
            .pulse      (act_pulse[g]),
            .wr_en      (bus_wr && ch_sel[g]),
            .ofs        (bus_addr[OFS_W-1:0]),
            .wdata      (bus_wdata),
            .rdata      (ch_rd[g]),
            .any_flag   (ch_flag[g]),
            .in_judge   (ch_judge[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == GADDR_STS)         bus_rdata = DATA_W'(ch_flag);
        else if (bus_addr == GADDR_PERIOD) bus_rdata = DATA_W'(period_q);
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) bus_rdata = ch_rd[i];
        end
    end

    assign irq = |ch_flag;

    AST_IRQ_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|ch_judge)); // R9

endmodule

// File: tb/act_monitor_test.sv
`timescale 1ns/1ps
module act_monitor_test;
    localparam int NCH = 2;
    localparam int TD  = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  act_pulse = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    act_monitor #(.NCH(NCH), .AW(12), .TICK_DIV(TD), .PER_W(8), .CH_BASE('h100)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_pulse(act_pulse), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_ctrl[NCH], m_hi[NCH], m_lo[NCH], m_init[NCH], m_ahi[NCH], m_alo[NCH];
    bit [31:0] m_w[NCH], m_avg[NCH], m_acc[NCH], m_snap[NCH];
    bit [3:0]  m_sts[NCH];
    int        m_rhi[NCH], m_rlo[NCH], m_st[NCH];
    int        m_pre, m_per;
    bit [7:0]  m_prd;

    function automatic bit [31:0] sadd(bit [31:0] a, bit [31:0] b);
        longint s = longint'(a) + longint'(b);
        return (s > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : s[31:0];
    endfunction

    task automatic model_step();
        bit ms, pend;
        if (!rst_n) begin
            m_pre = 0; m_per = 0; m_prd = 0;
            for (int c = 0; c < NCH; c++) begin
                m_ctrl[c] = 0; m_hi[c] = 0; m_lo[c] = 0; m_init[c] = 0; m_ahi[c] = 0;
                m_alo[c] = 0; m_w[c] = 0; m_avg[c] = 0; m_acc[c] = 0; m_snap[c] = 0;
                m_sts[c] = 0; m_rhi[c] = 0; m_rlo[c] = 0; m_st[c] = 0;
            end
            return;
        end
        ms   = (m_pre == TD - 1);
        pend = ms && (m_per >= int'(m_prd));
        m_pre = ms ? 0 : m_pre + 1;
        if (ms) m_per = pend ? 0 : m_per + 1;
        for (int c = 0; c < NCH; c++) begin
            bit [3:0]  setb = 0;
            bit [3:0]  clr  = 0;
            bit [31:0] add  = sadd(m_acc[c], act_pulse[c] ? m_w[c] : 32'd0);
            bit        en   = m_ctrl[c][31] && m_ctrl[c][18];
            int        base = 'h100 + c * 64;
            if (!en) begin
                m_st[c] = 0; m_acc[c] = 0; m_rhi[c] = 0; m_rlo[c] = 0;
            end else if (m_st[c] == 0) begin
                m_st[c] = 1; m_acc[c] = 0;
            end else if (m_st[c] == 1) begin
                if (pend) begin m_snap[c] = add; m_acc[c] = 0; m_st[c] = 2; end
                else m_acc[c] = add;
            end else begin
                longint diff, sh;
                bit [31:0] nav;
                m_acc[c] = add;
                m_st[c]  = 1;
                if (m_ctrl[c][30] && m_snap[c] > m_hi[c]) begin
                    if (m_rhi[c] >= int'(m_ctrl[c][28:26])) begin setb[3] = 1; m_rhi[c] = 0; end
                    else m_rhi[c]++;
                end else m_rhi[c] = 0;
                if (m_ctrl[c][29] && m_snap[c] < m_lo[c]) begin
                    if (m_rlo[c] >= int'(m_ctrl[c][25:23])) begin setb[2] = 1; m_rlo[c] = 0; end
                    else m_rlo[c]++;
                end else m_rlo[c] = 0;
                diff = longint'(m_snap[c]) - longint'(m_avg[c]);
                sh   = diff >>> (int'(m_ctrl[c][12:10]) + 1);
                nav  = m_avg[c] + sh[31:0];
                if (m_ctrl[c][21] && nav > m_ahi[c]) setb[1] = 1;
                if (m_ctrl[c][20] && nav < m_alo[c]) setb[0] = 1;
                m_avg[c] = nav;
            end
            if (bus_wr) begin
                case (int'(bus_addr) - base)
                    'h00: m_ctrl[c] = bus_wdata;
                    'h04: m_hi[c]   = bus_wdata;
                    'h08: m_lo[c]   = bus_wdata;
                    'h0C: begin m_init[c] = bus_wdata; m_avg[c] = bus_wdata; end
                    'h10: m_ahi[c]  = bus_wdata;
                    'h14: m_alo[c]  = bus_wdata;
                    'h18: m_w[c]    = bus_wdata;
                    'h24: clr       = bus_wdata[31:28];
                    default: ;
                endcase
            end
            m_sts[c] = (m_sts[c] & ~clr) | setb;
        end
        if (bus_wr && bus_addr == 12'h004) m_prd = bus_wdata[7:0];
    endtask

    function automatic bit [31:0] exp_rd(int a);
        bit [31:0] r = 0;
        if (a == 0) begin
            for (int c = 0; c < NCH; c++) r[c] = (m_sts[c] != 0);
        end else if (a == 4) begin
            r = {24'd0, m_prd};
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int off = a - ('h100 + c * 64);
                if (off >= 0 && off < 64) begin
                    case (off)
                        'h00: r = m_ctrl[c];
                        'h04: r = m_hi[c];
                        'h08: r = m_lo[c];
                        'h0C: r = m_init[c];
                        'h10: r = m_ahi[c];
                        'h14: r = m_alo[c];
                        'h18: r = m_w[c];
                        'h20: r = m_avg[c];
                        'h24: r = {m_sts[c], 28'd0};
                        default: r = 0;
                    endcase
                end
            end
        end
        return r;
    endfunction

    function automatic string tag_of(int a);
        int off = a & 'h3F;
        if (a == 0) return "R9";
        if (a == 4) return "R2";
        if (a >= 'h100 && off == 'h20) return "R4";
        if (a >= 'h100 && off == 'h24) return "R8";
        if (a >= 'h100 && off == 'h00) return "R10";
        return "R3";
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        bit        mirq;
        bit [31:0] e;
        model_step();
        #1;
        mirq = 0;
        for (int c = 0; c < NCH; c++) mirq |= (m_sts[c] != 0);
        check(irq === mirq, "R9 irq", {31'd0, irq}, {31'd0, mirq});
        e = exp_rd(int'(bus_addr));
        check(bus_rdata === e, tag_of(int'(bus_addr)), bus_rdata, e);
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic pat(int mode, int i);
        case (mode)
            1:       return 1'b1;
            2:       return (i % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [11:0] mon_addr(int i);
        case (i % 6)
            0: return 12'h120;
            1: return 12'h124;
            2: return 12'h000;
            3: return 12'h160;
            4: return 12'h164;
            default: return 12'h100;
        endcase
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #1 v = bus_rdata;
    endtask

    task automatic run(int n, int m0, int m1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act_pulse[0] = pat(m0, i);
            act_pulse[1] = pat(m1, i);
            bus_addr     = mon_addr(i);
        end
        @(negedge clk);
        act_pulse = '0;
    endtask

    // ctrl words: bit31 en, 30 cons-above, 29 cons-below, 28:26 N, 25:23 M,
    // 21 avg-above, 20 avg-below, 18 periodic, 12:10 K
    localparam logic [31:0] CTRL0 = 32'h8000_0000 | 32'h4000_0000 | 32'h2000_0000 |
                                    (32'd1 << 26) | (32'd2 << 23) | 32'h0020_0000 |
                                    32'h0010_0000 | 32'h0004_0000;
    localparam logic [31:0] CTRL1 = 32'h8000_0000 | 32'h4000_0000 | 32'h0020_0000 |
                                    32'h0004_0000 | (32'd1 << 10);

    initial begin
        logic [31:0] v, keep_s, keep_a;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(12'h004, v); check(v == 0, "R1 period", v, 0);
        rd(12'h124, v); check(v == 0, "R1 status", v, 0);
        rd(12'h100, v); check(v == 0, "R1 ctrl", v, 0);
        rd(12'h000, v); check(v == 0 && irq == 0, "R1 global", v, 0);

        wr(12'h004, 32'd2);
        rd(12'h004, v); check(v == 2, "R2 period readback", v, 2);

        wr(12'h104, 32'd30);  wr(12'h108, 32'd10);
        wr(12'h110, 32'd40);  wr(12'h114, 32'd5);
        wr(12'h118, 32'd5);   wr(12'h10C, 32'd20);
        rd(12'h120, v); check(v == 20, "R4 init load", v, 20);
        wr(12'h144, 32'd20);  wr(12'h148, 32'd4);
        wr(12'h150, 32'd100); wr(12'h158, 32'd3);

        wr(12'h100, CTRL0);
        wr(12'h140, CTRL1);
        run(60, 1, 2);
        rd(12'h124, v); check(v[31] == 1, "R5 cons above", v, 32'h8000_0000);
        rd(12'h000, v); check(v[0] == 1 && irq == 1, "R9 global bit", v, 1);

        // R10: stop keeps status and average, no evaluation happens
        wr(12'h100, 32'd0);
        rd(12'h124, keep_s);
        rd(12'h120, keep_a);
        run(40, 1, 0);
        rd(12'h124, v); check(v == keep_s, "R10 status kept", v, keep_s);
        rd(12'h120, v); check(v == keep_a, "R10 avg frozen", v, keep_a);
        wr(12'h124, 32'hF000_0000);
        rd(12'h124, v); check(v == 0, "R8 w1c", v, 0);
        rd(12'h000, v); check(v[0] == 0, "R9 bit clear", v, 0);

        // low activity: below run and average decay
        wr(12'h100, CTRL0);
        run(80, 0, 0);
        rd(12'h124, v); check(v[30] == 1, "R6 cons below", v, 32'h4000_0000);
        rd(12'h124, v); check(v[28] == 1, "R7 avg below", v, 32'h1000_0000);
        rd(12'h124, v); check(v[31] == 0, "R5 no false above", v, 0);
        rd(12'h164, v); check(v[30] == 0 && v[28] == 0, "R11 disabled conditions", v, 0);

        // R3: saturation of the count
        wr(12'h140, 32'd0);
        wr(12'h164, 32'hF000_0000);
        wr(12'h158, 32'hFFFF_FFFF);
        wr(12'h144, 32'hFFFF_FFFE);
        wr(12'h140, CTRL1);
        run(40, 0, 1);
        rd(12'h164, v); check(v[31] == 1, "R3 saturated count", v, 32'h8000_0000);

        run(30, 2, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule